// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the coherence directory that sits beside the memory slice of one node in a four-node distributed shared-memory machine. For every block stored in that slice it keeps a state (uncached, shared or exclusive) and a four-bit sharer vector with one bit per node. Nodes send it read-miss, write-miss and write-back requests. It answers with data replies, invalidations to sharers and fetch requests to the current owner, counts returning acknowledgements, and updates its memory slice when dirty data comes back.

The upper two address bits name the home node. A request whose upper bits do not match this controller's `HOME_ID` is taken off the request port and then dropped. Only one transaction is in flight at a time, and `req_ready` stays low until it has finished. Outgoing messages are registered and last one cycle. The fabric on the far side always accepts them.

Top module: `dirhome_ctl`

## Requirements
- R1: After reset every block is uncached with an empty sharer vector, every memory word reads zero, `req_ready` is 1 and `out_valid` is 0.
- R2: A request whose address bits [AW-1:AW-2] differ from `HOME_ID` produces no outgoing message and leaves directory and memory unchanged.
- R3: A read miss (`req_kind`=0) to an uncached or shared block sends a data message (`out_kind`=0) carrying the memory word to the requester. It appears in the second cycle after the accepting edge. The requester is added to the sharers and the block becomes shared.
- R4: A write miss (`req_kind`=1) to an uncached block sends a data message with the memory word to the requester in the second cycle after acceptance. The requester becomes the sole exclusive owner.
- R5: A write miss to a shared block sends an invalidate (`out_kind`=1) to each sharer other than the requester, one per cycle in ascending node order. The data reply is withheld until one acknowledgement per invalidate has arrived on `ack_vec`, in any grouping. The requester then becomes the exclusive owner.
- R6: A read miss to an exclusive block owned by another node sends a fetch (`out_kind`=2) to the owner. The returned `fetch_data` is written to memory and sent to the requester. The block becomes shared with the owner and the requester as sharers.
- R7: A write miss to an exclusive block owned by another node sends a fetch-and-invalidate (`out_kind`=3) to the owner. The returned data is written to memory and sent to the requester, and the requester becomes the new exclusive owner.
- R8: A write-back (`req_kind`=2) from the exclusive owner writes `req_data` to memory and makes the block uncached, with no message sent. A write-back from any node that is not the owner is ignored.
- R9: `req_ready` falls in the cycle after a request is accepted and stays low until the transaction has completed, invalidations and fetches included.
- R10: The directory entry stays self-consistent. Uncached has an empty vector, shared has at least one bit set, and exclusive has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_src | input | 2 | Requesting node |
| req_addr | input | AW | Block address, upper two bits name the home node |
| req_data | input | DW | Write-back data |
| ack_vec | input | 4 | Invalidate acknowledgements, one bit per node |
| fetch_valid | input | 1 | Owner's fetch response present |
| fetch_data | input | DW | Data returned by the owner |
| out_valid | output | 1 | Outgoing message valid for one cycle |
| out_kind | output | 2 | 0 data, 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| out_dst | output | 2 | Destination node |
| out_addr | output | AW | Block address with home bits |
| out_data | output | DW | Data for data messages |

## Verification
The assertions take for granted that the nodes behave: acknowledgements arrive only for invalidates that were sent, and never more than once per node. A fetch response is returned only while a fetch is outstanding. The bench acts as all four remote nodes and keeps to these rules. It acknowledges each invalidate after it has been observed, or holds the acknowledgements and releases them together. It answers each fetch exactly once, in the cycle after the fetch appears. Requests are issued only while `req_ready` is high.

// File: rtl/dirhome_pkg.sv
package dirhome_pkg;

    localparam int NODES = 4;
    localparam int NID_W = 2;
    localparam int CNT_W = $clog2(NODES + 1);

    typedef enum logic [1:0] {
        REQ_RD = 2'd0,
        REQ_WR = 2'd1,
        REQ_WB = 2'd2
    } req_kind_e;

    typedef enum logic [1:0] {
        MSG_DATA      = 2'd0,
        MSG_INV       = 2'd1,
        MSG_FETCH     = 2'd2,
        MSG_FETCH_INV = 2'd3
    } msg_kind_e;

    typedef enum logic [1:0] {
        DS_UNC = 2'd0,
        DS_SHR = 2'd1,
        DS_EXC = 2'd2
    } dstate_e;

    typedef struct packed {
        dstate_e            st;
        logic [NODES-1:0]   vec;
    } dir_ent_t;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_EVAL,
        FS_INV,
        FS_FETCH
    } fsm_e;

    function automatic logic [NODES-1:0] node_bit(input logic [NID_W-1:0] n);
        return NODES'(1) << n;
    endfunction

endpackage

// File: rtl/dirhome_pick.sv
module dirhome_pick
    import dirhome_pkg::*;
(
    input  logic [NODES-1:0] vec,
    output logic [NID_W-1:0] idx
);
    // lowest set bit wins
    always_comb begin
        idx = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (vec[i]) idx = NID_W'(i);
        end
    end
endmodule

// File: rtl/dirhome_ackcnt.sv
module dirhome_ackcnt
    import dirhome_pkg::*;
#(
    parameter int CW = CNT_W
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CW-1:0]    load_val,
    input  logic             en,
    input  logic [NODES-1:0] acks,
    output logic [CW-1:0]    cnt,
    output logic             zero_next
);
    logic [CW-1:0] dec;
    logic [CW-1:0] nxt;

    always_comb begin
        dec       = en ? CW'($countones(acks)) : '0;
        nxt       = cnt - dec;
        zero_next = (nxt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else           cnt <= nxt;
    end
endmodule

// File: rtl/dirhome_store.sv
module dirhome_store
    import dirhome_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int DW    = 32,
    localparam int NBLK = 1 << IDX_W
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic             dir_we,
    input  dir_ent_t         dir_wd,
    input  logic             mem_we,
    input  logic [DW-1:0]    mem_wd,
    output dir_ent_t         ent,
    output logic [DW-1:0]    mem_rd
);
    dir_ent_t      dir_q [NBLK];
    logic [DW-1:0] mem_q [NBLK];

    assign ent    = dir_q[idx];
    assign mem_rd = mem_q[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBLK; i++) begin
                dir_q[i] <= '{st: DS_UNC, vec: '0};
                mem_q[i] <= '0;
            end
        end else begin
            if (dir_we) dir_q[idx] <= dir_wd;
            if (mem_we) mem_q[idx] <= mem_wd;
        end
    end
endmodule

// File: rtl/dirhome_ctl.sv
module dirhome_ctl
    import dirhome_pkg::*;
#(
    parameter int          IDX_W   = 4,
    parameter int          DW      = 32,
    parameter logic [1:0]  HOME_ID = 2'd1,
    localparam int         AW      = IDX_W + 2
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_kind,
    input  logic [1:0]       req_src,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_data,
    input  logic [3:0]       ack_vec,
    input  logic             fetch_valid,
    input  logic [DW-1:0]    fetch_data,
    output logic             out_valid,
    output logic [1:0]       out_kind,
    output logic [1:0]       out_dst,
    output logic [AW-1:0]    out_addr,
    output logic [DW-1:0]    out_data
);
    fsm_e              st_q, st_d;
    req_kind_e         t_kind;
    logic [NID_W-1:0]  t_src;
    logic [IDX_W-1:0]  t_idx;
    logic [DW-1:0]     t_data;
    logic              t_home;
    logic [NODES-1:0]  inv_mask_q, inv_mask_d;

    dir_ent_t          ent, ent_wr;
    logic              dir_we, mem_we;
    logic [DW-1:0]     mem_wd, mem_rd;

    logic              cnt_load, cnt_zero_next;
    logic [CNT_W-1:0]  cnt_val, cnt_q;

    logic [NID_W-1:0]  own_idx, inv_idx;
    logic [NODES-1:0]  req_bit, others;

    logic              ov_q, ov_d;
    msg_kind_e         ok_q, ok_d;
    logic [NID_W-1:0]  od_q, od_d;
    logic [DW-1:0]     odata_q, odata_d;

    logic              accept;

    assign req_ready = (st_q == FS_IDLE);
    assign accept    = req_valid && req_ready;
    assign req_bit   = node_bit(t_src);
    assign others    = ent.vec & ~req_bit;

    dirhome_store #(.IDX_W(IDX_W), .DW(DW)) u_store (
        .clk(clk), .rst(rst), .idx(t_idx),
        .dir_we(dir_we), .dir_wd(ent_wr),
        .mem_we(mem_we), .mem_wd(mem_wd),
        .ent(ent), .mem_rd(mem_rd)
    );

    dirhome_ackcnt #(.CW(CNT_W)) u_ackcnt (
        .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val),
        .en(st_q == FS_INV), .acks(ack_vec),
        .cnt(cnt_q), .zero_next(cnt_zero_next)
    );

    dirhome_pick u_pick_own (.vec(ent.vec),    .idx(own_idx));
    dirhome_pick u_pick_inv (.vec(inv_mask_q), .idx(inv_idx));

    always_comb begin
        st_d       = st_q;
        dir_we     = 1'b0;
        ent_wr     = ent;
        mem_we     = 1'b0;
        mem_wd     = t_data;
        ov_d       = 1'b0;
        ok_d       = MSG_DATA;
        od_d       = t_src;
        odata_d    = mem_rd;
        inv_mask_d = inv_mask_q;
        cnt_load   = 1'b0;
        cnt_val    = '0;

        unique case (st_q)
            FS_IDLE: if (accept) st_d = FS_EVAL;

            FS_EVAL: begin
                st_d = FS_IDLE;
                if (t_home) begin
                    case (t_kind)
                        REQ_RD: begin
                            if (ent.st == DS_EXC && ent.vec != req_bit) begin
                                ov_d = 1'b1;  ok_d = MSG_FETCH;  od_d = own_idx;
                                st_d = FS_FETCH;
                            end else begin
                                ov_d = 1'b1;
                                if (ent.st != DS_EXC) begin
                                    dir_we     = 1'b1;
                                    ent_wr.st  = DS_SHR;
                                    ent_wr.vec = ent.vec | req_bit;
                                end
                            end
                        end
                        REQ_WR: begin
                            if (ent.st == DS_EXC && ent.vec != req_bit) begin
                                ov_d = 1'b1;  ok_d = MSG_FETCH_INV;  od_d = own_idx;
                                st_d = FS_FETCH;
                            end else if (ent.st == DS_SHR && others != '0) begin
                                inv_mask_d = others;
                                cnt_load   = 1'b1;
                                cnt_val    = CNT_W'($countones(others));
                                st_d       = FS_INV;
                            end else begin
                                ov_d       = 1'b1;
                                dir_we     = 1'b1;
                                ent_wr.st  = DS_EXC;
                                ent_wr.vec = req_bit;
                            end
                        end
                        REQ_WB: begin
                            if (ent.st == DS_EXC && ent.vec == req_bit) begin
                                mem_we     = 1'b1;
                                dir_we     = 1'b1;
                                ent_wr.st  = DS_UNC;
                                ent_wr.vec = '0;
                            end
                        end
                        default: ;
                    endcase
                end
            end

            FS_INV: begin
                if (inv_mask_q != '0) begin
                    ov_d       = 1'b1;
                    ok_d       = MSG_INV;
                    od_d       = inv_idx;
                    inv_mask_d = inv_mask_q & ~node_bit(inv_idx);
                end else if (cnt_zero_next) begin
                    ov_d       = 1'b1;
                    dir_we     = 1'b1;
                    ent_wr.st  = DS_EXC;
                    ent_wr.vec = req_bit;
                    st_d       = FS_IDLE;
                end
            end

            FS_FETCH: begin
                if (fetch_valid) begin
                    mem_we  = 1'b1;
                    mem_wd  = fetch_data;
                    ov_d    = 1'b1;
                    odata_d = fetch_data;
                    dir_we  = 1'b1;
                    if (t_kind == REQ_RD) begin
                        ent_wr.st  = DS_SHR;
                        ent_wr.vec = ent.vec | req_bit;
                    end else begin
                        ent_wr.st  = DS_EXC;
                        ent_wr.vec = req_bit;
                    end
                    st_d = FS_IDLE;
                end
            end

            default: st_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= FS_IDLE;
            t_kind     <= REQ_RD;
            t_src      <= '0;
            t_idx      <= '0;
            t_data     <= '0;
            t_home     <= 1'b0;
            inv_mask_q <= '0;
            ov_q       <= 1'b0;
            ok_q       <= MSG_DATA;
            od_q       <= '0;
            odata_q    <= '0;
        end else begin
            st_q       <= st_d;
            inv_mask_q <= inv_mask_d;
            ov_q       <= ov_d;
            ok_q       <= ok_d;
            od_q       <= od_d;
            odata_q    <= odata_d;
            if (accept) begin
                t_kind <= req_kind_e'(req_kind);
                t_src  <= req_src;
                t_idx  <= req_addr[IDX_W-1:0];
                t_data <= req_data;
                t_home <= (req_addr[AW-1:AW-2] == HOME_ID);
            end
        end
    end

    assign out_valid = ov_q;
    assign out_kind  = ok_q;
    assign out_dst   = od_q;
    assign out_addr  = {HOME_ID, t_idx};
    assign out_data  = odata_q;

endmodule

// File: rtl/dirhome_chk.sv
module dirhome_chk
    import dirhome_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             out_valid,
    input logic [1:0]       out_kind,
    input logic [1:0]       out_dst,
    input logic [1:0]       t_src,
    input logic [1:0]       ent_st,
    input logic [NODES-1:0] ent_vec,
    input logic [CNT_W-1:0] cnt
);
    // R9
    serial_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    excl_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (ent_st == DS_EXC) |-> $onehot(ent_vec));

    // R10
    unc_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (ent_st == DS_UNC) |-> (ent_vec == '0));

    // R10
    shr_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        (ent_st == DS_SHR) |-> (ent_vec != '0));

    // R5
    reply_after_acks_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == MSG_DATA) |-> (cnt == '0));

    // R5
    inv_not_req_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == MSG_INV) |-> (out_dst != t_src));

    // R9
    busy_during_inv_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == MSG_INV) |-> !req_ready);
endmodule

bind dirhome_ctl dirhome_chk u_chk (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .out_valid(out_valid), .out_kind(out_kind), .out_dst(out_dst),
    .t_src(t_src), .ent_st(ent.st), .ent_vec(ent.vec), .cnt(cnt_q)
);

// File: tb/dirhome_ctl_bench.sv
module dirhome_ctl_bench;
    localparam int         IDX_W = 4;
    localparam int         DW    = 32;
    localparam logic [1:0] HOME  = 2'd1;
    localparam int         AW    = IDX_W + 2;

    localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_WB = 2'd2;
    localparam logic [1:0] M_DATA = 2'd0, M_INV = 2'd1, M_FET = 2'd2, M_FETI = 2'd3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_kind = '0, req_src = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [3:0] ack_vec = '0;
    logic fetch_valid = 1'b0;
    logic [DW-1:0] fetch_data = '0;
    logic out_valid;
    logic [1:0] out_kind, out_dst;
    logic [AW-1:0] out_addr;
    logic [DW-1:0] out_data;

    dirhome_ctl #(.IDX_W(IDX_W), .DW(DW), .HOME_ID(HOME)) u_dirhome_ctl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_src(req_src), .req_addr(req_addr),
        .req_data(req_data), .ack_vec(ack_vec), .fetch_valid(fetch_valid),
        .fetch_data(fetch_data), .out_valid(out_valid), .out_kind(out_kind),
        .out_dst(out_dst), .out_addr(out_addr), .out_data(out_data)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    logic [1:0]    lg_k [16];
    logic [1:0]    lg_d [16];
    logic [AW-1:0] lg_a [16];
    logic [DW-1:0] lg_v [16];
    int            lg_c [16];
    int            lg_n = 0;

    logic [3:0]    ack_pend = '0;
    bit            hold_acks = 1'b0;
    bit            fet_pend = 1'b0;
    logic [DW-1:0] fet_val = '0;
    int            acc = 0;

    // remote nodes: log messages, acknowledge invalidates, answer fetches
    always @(negedge clk) begin
        ack_vec     = '0;
        fetch_valid = 1'b0;
        if (!hold_acks && ack_pend != '0) begin
            ack_vec  = ack_pend;
            ack_pend = '0;
        end
        if (fet_pend) begin
            fetch_valid = 1'b1;
            fetch_data  = fet_val;
            fet_pend    = 1'b0;
        end
        if (out_valid) begin
            if (lg_n < 16) begin
                lg_k[lg_n] = out_kind;  lg_d[lg_n] = out_dst;
                lg_a[lg_n] = out_addr;  lg_v[lg_n] = out_data;
                lg_c[lg_n] = cyc;
            end
            lg_n++;
            if (out_kind == M_INV) ack_pend[out_dst] = 1'b1;
            if (out_kind == M_FET || out_kind == M_FETI) fet_pend = 1'b1;
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    always @(posedge clk) begin
        if (cyc > 100000 && !done) begin
            n_tests++; n_fail++;
            $display("FAIL R9 watchdog: actual %0d cycles, expected completion", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] k, input logic [1:0] src,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
        lg_n = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_src = src; req_addr = a; req_data = d;
        @(posedge clk); #1;
        acc = cyc;
        req_valid = 1'b0;
        @(negedge clk);
        chk(!req_ready, "R9", "ready after accept", req_ready, 0);
    endtask

    task automatic settle();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic exp_msg(input int i, input logic [1:0] k, input logic [1:0] dst,
                           input logic [AW-1:0] a, input logic [DW-1:0] v, input string rq);
        chk(lg_n > i, rq, "message present", lg_n, i + 1);
        if (lg_n > i) begin
            chk(lg_k[i] == k,   rq, "kind", lg_k[i], k);
            chk(lg_d[i] == dst, rq, "dest", lg_d[i], dst);
            chk(lg_a[i] == a,   rq, "addr", lg_a[i], a);
            if (k == M_DATA) chk(lg_v[i] == v, rq, "data", lg_v[i], v);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "ready at reset", req_ready, 1);
        chk(out_valid == 1'b0, "R1", "no message at reset", out_valid, 0);

        // R2 wrong-home requests to block 3 leave it untouched (checked by sweep step a/c)
        send(K_WR, 2'd0, {2'b10, 4'd3}, '0);          settle();
        chk(lg_n == 0, "R2", "wrong-home write msgs", lg_n, 0);
        send(K_RD, 2'd2, {2'b00, 4'd3}, '0);          settle();
        chk(lg_n == 0, "R2", "wrong-home read msgs", lg_n, 0);
        send(K_WB, 2'd1, {2'b11, 4'd3}, 32'hBAD0_BAD0); settle();
        chk(lg_n == 0, "R2", "wrong-home writeback msgs", lg_n, 0);

        for (int b = 0; b < 16; b++) begin
            logic [AW-1:0] a;
            logic [1:0] o, r1, r2, r3, lo, hi;
            logic [DW-1:0] v, w, f, y;
            a  = {HOME, 4'(b)};
            o  = 2'(b);  r1 = o + 2'd1;  r2 = o + 2'd2;  r3 = o + 2'd3;
            v  = 32'hA000_0000 + 32'(b * 17);
            w  = 32'h5A00_0000 | 32'(b);
            f  = 32'h0F00_0000 + 32'(b);
            y  = 32'h7700_0000 + 32'(b);

            // R4 write miss on uncached block, memory zero from R1
            send(K_WR, o, a, '0); settle();
            chk(lg_n == 1, "R4", "message count", lg_n, 1);
            exp_msg(0, M_DATA, o, a, '0, "R4");
            chk(lg_c[0] == acc + 1, "R4", "reply cycle", lg_c[0], acc + 1);

            // R8 owner write-back, silent
            send(K_WB, o, a, v); settle();
            chk(lg_n == 0, "R8", "writeback silent", lg_n, 0);

            // R3 read misses on uncached then shared
            send(K_RD, r1, a, '0); settle();
            chk(lg_n == 1, "R3", "message count", lg_n, 1);
            exp_msg(0, M_DATA, r1, a, v, "R3");
            chk(lg_c[0] == acc + 1, "R3", "reply cycle", lg_c[0], acc + 1);
            send(K_RD, r2, a, '0); settle();
            exp_msg(0, M_DATA, r2, a, v, "R3");

            // R5 write miss on shared block
            lo = (r1 < r2) ? r1 : r2;  hi = (r1 < r2) ? r2 : r1;
            if (b == 5) begin
                hold_acks = 1'b1;
                send(K_WR, r3, a, '0);
                repeat (8) @(negedge clk);
                chk(lg_n == 2, "R5", "no reply while acks held", lg_n, 2);
                chk(!req_ready, "R9", "busy while acks held", req_ready, 0);
                #1 hold_acks = 1'b0;
                settle();
            end else begin
                send(K_WR, r3, a, '0); settle();
            end
            chk(lg_n == 3, "R5", "message count", lg_n, 3);
            exp_msg(0, M_INV, lo, a, '0, "R5");
            exp_msg(1, M_INV, hi, a, '0, "R5");
            exp_msg(2, M_DATA, r3, a, v, "R5");
            chk(lg_c[0] == acc + 2, "R5", "first invalidate cycle", lg_c[0], acc + 2);
            chk(lg_c[1] == lg_c[0] + 1, "R5", "invalidates back to back", lg_c[1], lg_c[0] + 1);

            // R6 read miss on exclusive block
            fet_val = w;
            send(K_RD, r1, a, '0); settle();
            chk(lg_n == 2, "R6", "message count", lg_n, 2);
            exp_msg(0, M_FET, r3, a, '0, "R6");
            exp_msg(1, M_DATA, r1, a, w, "R6");

            // R6 memory updated and both nodes shared: write miss invalidates r1 and r3
            lo = (r1 < r3) ? r1 : r3;  hi = (r1 < r3) ? r3 : r1;
            send(K_WR, r2, a, '0); settle();
            chk(lg_n == 3, "R6", "sharers after fetch", lg_n, 3);
            exp_msg(0, M_INV, lo, a, '0, "R6");
            exp_msg(1, M_INV, hi, a, '0, "R6");
            exp_msg(2, M_DATA, r2, a, w, "R6");

            // R7 write miss on exclusive block
            fet_val = f;
            send(K_WR, o, a, '0); settle();
            chk(lg_n == 2, "R7", "message count", lg_n, 2);
            exp_msg(0, M_FETI, r2, a, '0, "R7");
            exp_msg(1, M_DATA, o, a, f, "R7");

            // R8 write-back from the former owner is ignored
            send(K_WB, r2, a, 32'hDEAD_0000); settle();
            chk(lg_n == 0, "R8", "non-owner writeback silent", lg_n, 0);
            fet_val = y;
            send(K_RD, r1, a, '0); settle();
            exp_msg(0, M_FET, o, a, '0, "R8");
            exp_msg(1, M_DATA, r1, a, y, "R8");
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule